// File: doc/BRIEF.md
# Stuck Bus Timeout Monitor

This block guards a two-wire bus switch against a downstream segment that is held low. It receives two digital indications, one per shared downstream node (data and clock), each high when that node is above the logic threshold. Whenever either node is low, a cycle counter runs. When it reaches the terminal count picked by a 2-bit select, the block tells the connection controller to drop every downstream channel. It also raises a present status bit, a latched status bit and an alert request. The counter returns to zero only when both nodes are high at once.

The terminal counts come from the `CLK_HZ` parameter. Select code 2'b00 turns the timeout off, 2'b01 selects 30 ms, 2'b10 selects 15 ms and 2'b11 selects 7.5 ms. The counts are computed as CLK_HZ·3/100, CLK_HZ·3/200 and CLK_HZ·3/400 cycles. Software clears the latched bit with a one-cycle write strobe. This strobe stands for the dummy write to the read-only status register.

The control is a three-state machine:
- MON_IDLE: no line is low, or the timeout is off.
- MON_TIMING: a line is low and the counter is running.
- MON_EXPIRED: the limit has been reached.

Its transitions are:
- IDLE→TIMING (start): a line is low while the timeout is enabled.
- IDLE→EXPIRED (instant): as start, but the limit is reached on that same edge.
- TIMING→EXPIRED (expire): the counter hits the limit.
- TIMING→IDLE (release): both lines are high, or the timeout is disabled.
- EXPIRED→IDLE (recover): both lines are high, or the timeout is disabled.

Top module: `stuck_bus_monitor`

## Requirements
- R1: With an enabled select, a low on the data line, the clock line or both produces the expiry on exactly the Nth rising clock edge that samples a line low, where N is the selected terminal count.
- R2: The count restarts from zero only on an edge where both lines are sampled high. Toggling one line while the other stays low does not delay expiry.
- R3: Select 2'b01 gives N = CLK_HZ·3/100, 2'b10 gives N = CLK_HZ·3/200 and 2'b11 gives N = CLK_HZ·3/400.
- R4: Select 2'b00 holds the counter at zero. No disconnect is produced however long a line is low, and the state drops to IDLE on the edge after the select changes to 2'b00.
- R5: `disconnect` is high for exactly one cycle, on entry to the expired state.
- R6: `tmo_now` is high while expired and falls on the first edge that samples both lines high.
- R7: `tmo_latched` rises with expiry, stays high after the lines recover, and falls on the edge that samples `clr_strobe` high.
- R8: When expiry and `clr_strobe` fall on the same edge, `tmo_latched` ends up set.
- R9: `alert_req` is high exactly when `tmo_latched` is high.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_high | input | 1 | Data node above threshold |
| scl_high | input | 1 | Clock node above threshold |
| tmo_sel | input | 2 | Timeout select: 00 off, 01 30 ms, 10 15 ms, 11 7.5 ms |
| clr_strobe | input | 1 | One-cycle clear of the latched timeout |
| disconnect | output | 1 | One-cycle request to drop all downstream channels |
| tmo_now | output | 1 | Present timeout status |
| tmo_latched | output | 1 | Latched timeout status |
| alert_req | output | 1 | Fault alert request, active high |

## Verification
Two functions can land on one edge: expiry setting the latched bit, and the software clear resetting it. The bench holds a line low and raises `clr_strobe` just before the Nth edge. After that edge it expects the latched bit and the alert request to be high, since the set wins. A separate test pulses the clear after the lines recover and expects the bit to fall, so that the clear is shown to work when it does not collide with an expiry.

// File: rtl/stuck_mon_pkg.sv
package stuck_mon_pkg;

    typedef enum logic [1:0] {
        MON_IDLE    = 2'd0,
        MON_TIMING  = 2'd1,
        MON_EXPIRED = 2'd2
    } mon_state_e;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_30MS = 2'b01;
    localparam logic [1:0] SEL_15MS = 2'b10;
    localparam logic [1:0] SEL_7MS5 = 2'b11;

endpackage

// File: rtl/stuck_limit_sel.sv
module stuck_limit_sel #(
    parameter int CLK_HZ = 250_000_000,
    parameter int CW     = 23
) (
    input  logic [1:0]    sel,
    output logic          enable,
    output logic [CW-1:0] limit
);
    import stuck_mon_pkg::*;

    localparam int L30 = CLK_HZ / 100 * 3;
    localparam int L15 = CLK_HZ / 200 * 3;
    localparam int L7  = CLK_HZ / 400 * 3;

    always_comb begin
        enable = 1'b1;
        limit  = '0;
        unique case (sel)
            SEL_OFF:  enable = 1'b0;
            SEL_30MS: limit  = CW'(L30);
            SEL_15MS: limit  = CW'(L15);
            SEL_7MS5: limit  = CW'(L7);
            default:  enable = 1'b0;
        endcase
    end

endmodule

// File: rtl/stuck_low_counter.sv
module stuck_low_counter #(
    parameter int CW = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (cnt < limit)
            cnt <= cnt + CW'(1);
    end

    assign hit = run && (cnt >= limit - CW'(1));

    assert_cnt_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

    assert_cnt_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt < limit) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/stuck_mon_fsm.sv
module stuck_mon_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic low_any,
    input  logic hit,
    input  logic clr,
    output logic disconnect,
    output logic tmo_now,
    output logic tmo_latched
);
    import stuck_mon_pkg::*;

    mon_state_e state, nxt;
    logic       entry;

    always_comb begin
        nxt = state;
        unique case (state)
            MON_IDLE:    if (en && low_any) nxt = hit ? MON_EXPIRED : MON_TIMING;
            MON_TIMING:  if (!en || !low_any) nxt = MON_IDLE;
                         else if (hit) nxt = MON_EXPIRED;
            MON_EXPIRED: if (!en || !low_any) nxt = MON_IDLE;
            default:     nxt = MON_IDLE;
        endcase
    end

    assign entry = (nxt == MON_EXPIRED) && (state != MON_EXPIRED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MON_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disconnect  <= 1'b0;
            tmo_now     <= 1'b0;
            tmo_latched <= 1'b0;
        end else begin
            disconnect <= entry;
            tmo_now    <= (nxt == MON_EXPIRED);
            if (entry)    tmo_latched <= 1'b1;
            else if (clr) tmo_latched <= 1'b0;
        end
    end

    assert_no_disc_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!disconnect && !tmo_now));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |=> !disconnect);

    assert_now_recovers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_now && !low_any) |=> !tmo_now);

    assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_latched && !clr) |=> tmo_latched);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_now) |-> tmo_latched);

endmodule

// File: rtl/stuck_bus_monitor.sv
module stuck_bus_monitor #(
    parameter int CLK_HZ = 250_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_high,
    input  logic       scl_high,
    input  logic [1:0] tmo_sel,
    input  logic       clr_strobe,
    output logic       disconnect,
    output logic       tmo_now,
    output logic       tmo_latched,
    output logic       alert_req
);
    localparam int CW = $clog2(CLK_HZ / 100 * 3 + 1);

    logic          en;
    logic          low_any;
    logic          hit;
    logic [CW-1:0] limit;

    assign low_any = !sda_high || !scl_high;

    stuck_limit_sel #(.CLK_HZ(CLK_HZ), .CW(CW)) u_sel (
        .sel    (tmo_sel),
        .enable (en),
        .limit  (limit)
    );

    stuck_low_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en && low_any),
        .limit (limit),
        .hit   (hit)
    );

    stuck_mon_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .low_any     (low_any),
        .hit         (hit),
        .clr         (clr_strobe),
        .disconnect  (disconnect),
        .tmo_now     (tmo_now),
        .tmo_latched (tmo_latched)
    );

    assign alert_req = tmo_latched;

    assert_alert_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alert_req == tmo_latched);

endmodule

// File: tb/tb_stuck_bus_monitor.sv
module tb_stuck_bus_monitor;
    localparam int CLK_HZ = 4000;
    localparam int N30 = CLK_HZ / 100 * 3;
    localparam int N15 = CLK_HZ / 200 * 3;
    localparam int N7  = CLK_HZ / 400 * 3;

    // {sel[1:0], {sda_low, scl_low}, expected edge count (0 = never)}
    localparam logic [11:0] VEC [0:5] = '{
        {2'b11, 2'b10, 8'd30},
        {2'b11, 2'b01, 8'd30},
        {2'b11, 2'b11, 8'd30},
        {2'b10, 2'b10, 8'd60},
        {2'b01, 2'b01, 8'd120},
        {2'b00, 2'b11, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sda_high = 1'b1, scl_high = 1'b1, clr_strobe = 1'b0;
    logic [1:0] tmo_sel = 2'b11;
    logic disconnect, tmo_now, tmo_latched, alert_req;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    stuck_bus_monitor #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .rst_n(rst_n), .sda_high(sda_high), .scl_high(scl_high),
        .tmo_sel(tmo_sel), .clr_strobe(clr_strobe), .disconnect(disconnect),
        .tmo_now(tmo_now), .tmo_latched(tmo_latched), .alert_req(alert_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_disc(input int maxn, output int n);
        n = 0;
        for (int i = 1; i <= maxn; i++) begin
            @(negedge clk);
            if (disconnect && n == 0) n = i;
        end
    endtask

    task automatic recover();
        @(negedge clk);
        sda_high = 1'b1; scl_high = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(!disconnect && !tmo_now && !tmo_latched && !alert_req, "R10 reset outputs", 
            {disconnect, tmo_now, tmo_latched, alert_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            tmo_sel  = VEC[v][11:10];
            sda_high = !VEC[v][9];
            scl_high = !VEC[v][8];
            wait_disc(140, n);
            chk(n == int'(VEC[v][7:0]), "R1/R3/R4 expiry edge", n, int'(VEC[v][7:0]));
            recover();
        end

        // R5 one-cycle pulse, R6 present bit, R7 latch, R9 alert
        tmo_sel = 2'b11; sda_high = 1'b0;
        repeat (N7) @(negedge clk);
        chk(disconnect == 1'b1, "R5 pulse present", disconnect, 1);
        @(negedge clk);
        chk(disconnect == 1'b0, "R5 pulse one cycle", disconnect, 0);
        chk(tmo_now == 1'b1, "R6 present while stuck", tmo_now, 1);
        sda_high = 1'b1;
        @(negedge clk);
        chk(tmo_now == 1'b0, "R6 present drops on release", tmo_now, 0);
        chk(tmo_latched == 1'b1, "R7 latch held after release", tmo_latched, 1);
        chk(alert_req == 1'b1, "R9 alert follows latch", alert_req, 1);
        repeat (5) @(negedge clk);
        chk(tmo_latched == 1'b1, "R7 latch still held", tmo_latched, 1);
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
        chk(tmo_latched == 1'b0, "R7 latch cleared", tmo_latched, 0);
        chk(alert_req == 1'b0, "R9 alert cleared", alert_req, 0);

        // R2: toggle data while clock stays low
        scl_high = 1'b0;
        n = 0;
        for (int i = 1; i <= N7 + 5; i++) begin
            sda_high = ~sda_high;
            @(negedge clk);
            if (disconnect && n == 0) n = i;
        end
        chk(n == N7, "R2 toggle does not restart", n, N7);
        recover();

        // R2: both high for one edge restarts
        sda_high = 1'b0;
        repeat (20) @(negedge clk);
        sda_high = 1'b1;
        @(negedge clk);
        sda_high = 1'b0;
        wait_disc(N7 + 5, n);
        chk(n == N7, "R2 restart after both high", n, N7);

        // R4 disabling while expired drops the present bit
        tmo_sel = 2'b00;
        @(negedge clk);
        chk(tmo_now == 1'b0, "R4 disable clears present", tmo_now, 0);
        recover();

        // R8 expiry and clear on the same edge
        tmo_sel = 2'b11; scl_high = 1'b0;
        repeat (N7 - 1) @(negedge clk);
        clr_strobe = 1'b1;
        @(negedge clk);
        clr_strobe = 1'b0;
        chk(tmo_latched == 1'b1, "R8 set wins over clear", tmo_latched, 1);
        chk(alert_req == 1'b1, "R8 alert raised", alert_req, 1);
        chk(disconnect == 1'b1, "R8 disconnect on collision edge", disconnect, 1);
        recover();
        chk(N15 == 2 * N7 && N30 == 4 * N7, "R3 ratio", N30, 4 * N7);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule